// File: doc/BRIEF.md
# Unlock-Sequenced Byte Flash Model

This block models the command logic of a byte-wide parallel flash array. Every command is guarded by an unlock handshake: two bus writes with fixed data to two fixed addresses. Once unlocked, a third write names the action. The actions are entering or leaving an identification read mode, starting a whole-array erase (which needs a second unlock and a confirm byte), and arming a one-byte program. Reads on the same bus return array bytes, identification bytes, or, while an erase is running, a status byte whose bit 6 toggles.

The bus is synchronous. A write takes one cycle with `wrEn` high. A read takes one cycle with `rdEn` high, and its data appears on `rdData` at the following edge. The storage is a plain behavioural byte array that walks one address per clock during erase, so it maps onto a single-port RAM. The full part is 128 KB, with `MEM_AW` = 17. The default `MEM_AW` is 11, and the array then mirrors across the 17-bit address space.

Top module: `unlock_flash_core`

## Requirements
- R1: After reset, `busy` is 0, `rdData` is 0x00, the array read mode is selected and no command sequence is in progress.
- R2: A read with `rdEn` high returns the selected byte on `rdData` from the next clock edge on. `rdData` holds its value in every cycle without `rdEn`.
- R3: The sequence 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555 enters identification mode. In this mode, address 0 reads the maker code (default 0xBF), address 1 reads the device code (default 0x07), and all other addresses read 0x00.
- R4: The unlock pair followed by 0xF0@0x5555 leaves identification mode, and reads return array bytes again.
- R5: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555 set every array byte to 0xFF. `busy` is high for exactly 2^MEM_AW cycles, starting at the edge that takes the last write.
- R6: While `busy` is high, a read returns a status byte in which every bit except bit 6 is 0. Bit 6 is 0 on the first read after the erase starts and inverts on each further read. Writes while `busy` is high are ignored.
- R7: The unlock pair followed by 0xA0@0x5555 arms a program. The next write, at any address, replaces that byte with (old AND data), so programming can only clear bits.
- R8: A write that does not match the next expected step of a sequence returns the sequencer to idle. The array and the mode are unchanged.
- R9: Only address bits 14:0 are compared against 0x5555 and 0x2AAA, so 0x15555 and 0x1AAAA also unlock.
- R10: The array is indexed by address bits MEM_AW-1:0. Addresses that differ only above that range reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (17) | Byte address for reads and writes |
| wrData | input | 8 | Write data byte |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Read data, registered |
| busy | output | 1 | High while an erase is running |

## Verification
The hardest state to reach is an erase in flight combined with further bus traffic. The bench has to complete the six-write erase, and then, inside the busy window, issue paired status reads and a full program sequence that must leave no trace. It does this right after the confirm write, and then checks the programmed address after `busy` falls. The aborted-sequence cases also need care: each one stops at a different step, and the final write has to be one that would have acted if the sequence were still live.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int MATCH_W = 15;
  localparam logic [MATCH_W-1:0] UNLOCK_A = 15'h5555;
  localparam logic [MATCH_W-1:0] UNLOCK_B = 15'h2AAA;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_ID_ON   = 8'h90;
  localparam logic [7:0] CMD_ID_OFF  = 8'hF0;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_ERA1, SQ_ERA2, SQ_ERA3, SQ_PROG
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic eraseGo;
    logic idOn;
    logic idOff;
  } seq_stb_t;

endpackage

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output seq_stb_t          stb
);

  seq_state_t state, nxt;
  logic hitA, hitB;

  assign hitA = (addr[MATCH_W-1:0] == UNLOCK_A);
  assign hitB = (addr[MATCH_W-1:0] == UNLOCK_B);

  always_comb begin
    nxt = state;
    stb = '0;
    if (wrEn && !busy) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE: if (hitA && wrData == CMD_KEY1) nxt = SQ_UNL1;
        SQ_UNL1: if (hitB && wrData == CMD_KEY2) nxt = SQ_UNL2;
        SQ_UNL2: begin
          if (hitA) begin
            unique case (wrData)
              CMD_ID_ON:  stb.idOn  = 1'b1;
              CMD_ID_OFF: stb.idOff = 1'b1;
              CMD_PROG:   nxt = SQ_PROG;
              CMD_ERASE:  nxt = SQ_ERA1;
              default:    nxt = SQ_IDLE;
            endcase
          end
        end
        SQ_ERA1: if (hitA && wrData == CMD_KEY1) nxt = SQ_ERA2;
        SQ_ERA2: if (hitB && wrData == CMD_KEY2) nxt = SQ_ERA3;
        SQ_ERA3: if (hitA && wrData == CMD_CONFIRM) stb.eraseGo = 1'b1;
        SQ_PROG: stb.prog = 1'b1;
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W = 17,
  parameter int         MEM_AW = 11,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_stb_t          stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              busy
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam int STATUS_BIT = 6;

  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] memIdx;
  logic [MEM_AW-1:0] eraseIdx;
  logic              erasing;
  logic              togBit;
  logic              idMode;
  logic [7:0]        statusByte;

  assign memIdx = addr[MEM_AW-1:0];
  assign busy   = erasing;

  always_comb begin
    statusByte = '0;
    statusByte[STATUS_BIT] = togBit;
  end

  // array write port: erase walk or single-byte program
  always_ff @(posedge clk) begin
    if (erasing)       mem[eraseIdx] <= 8'hFF;
    else if (stb.prog) mem[memIdx]   <= mem[memIdx] & wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erasing  <= 1'b0;
      eraseIdx <= '0;
      togBit   <= 1'b0;
      idMode   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (rdEn) begin
        if (erasing) begin
          rdData <= statusByte;
          togBit <= ~togBit;
        end else if (idMode) begin
          if (addr == '0)                rdData <= MFR_ID;
          else if (addr == ADDR_W'(1))   rdData <= DEV_ID;
          else                           rdData <= 8'h00;
        end else begin
          rdData <= mem[memIdx];
        end
      end
      if (stb.idOn)  idMode <= 1'b1;
      if (stb.idOff) idMode <= 1'b0;
      if (stb.eraseGo) begin
        erasing  <= 1'b1;
        eraseIdx <= '0;
        togBit   <= 1'b0;
      end else if (erasing) begin
        eraseIdx <= eraseIdx + 1'b1;
        if (eraseIdx == {MEM_AW{1'b1}}) erasing <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/unlock_flash_core.sv
module unlock_flash_core
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W = 17,
  parameter int         MEM_AW = 11,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              busy
);

  seq_stb_t ctlStb;

  flash_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .busy(busy), .stb(ctlStb)
  );

  flash_seq_dp #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(ctlStb), .addr(addr),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .busy(busy)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic              busy,
  input seq_stb_t          stb
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [MEM_AW:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busyRun <= '0;
    else                 busyRun <= busyRun + 1'b1;
  end

  AST_ERASE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyRun < (MEM_AW+1)'(DEPTH))); // R5
  AST_ERASE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busyRun) == (MEM_AW+1)'(DEPTH-1))); // R5
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wrEn && addr[MATCH_W-1:0] == UNLOCK_A && wrData == CMD_CONFIRM)); // R5
  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && busy) |=> ((rdData & 8'hBF) == 8'h00)); // R6
  AST_NO_ACTION_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stb == '0)); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdData)); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb)); // R8

endmodule

bind unlock_flash_core flash_seq_chk #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .busy(busy), .stb(ctlStb)
);

// File: tb/unlock_flash_core_bench.sv
module unlock_flash_core_bench;

  localparam int ADDR_W = 17;
  localparam int MEM_AW = 11;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam logic [7:0] MFR = 8'hBF;
  localparam logic [7:0] DEV = 8'h07;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wrData = '0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [7:0]        rdData;
  logic              busy;

  int total = 0;
  int bad = 0;
  bit started = 0;

  always #5 clk = ~clk;

  unlock_flash_core #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_unlock_flash_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .busy(busy)
  );

  // behavioural reference model
  logic [7:0] mMem [DEPTH];
  int         mSeq;
  bit         mId;
  int         mBusy;
  bit         mTog;
  logic [7:0] mRd;

  task automatic modelWrite();
    bit a5 = (addr[14:0] == 15'h5555);
    bit a2 = (addr[14:0] == 15'h2AAA);
    case (mSeq)
      0: if (a5 && wrData == 8'hAA) mSeq = 1;
      1: mSeq = (a2 && wrData == 8'h55) ? 2 : 0;
      2: begin
        mSeq = 0;
        if (a5) begin
          if (wrData == 8'h90) mId = 1;
          else if (wrData == 8'hF0) mId = 0;
          else if (wrData == 8'hA0) mSeq = 6;
          else if (wrData == 8'h80) mSeq = 3;
        end
      end
      3: mSeq = (a5 && wrData == 8'hAA) ? 4 : 0;
      4: mSeq = (a2 && wrData == 8'h55) ? 5 : 0;
      5: begin
        mSeq = 0;
        if (a5 && wrData == 8'h10) begin
          for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;
          mBusy = DEPTH;
          mTog = 0;
        end
      end
      default: begin
        mMem[addr % DEPTH] = mMem[addr % DEPTH] & wrData;
        mSeq = 0;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mSeq = 0; mId = 0; mBusy = 0; mTog = 0; mRd = 8'h00;
    end else begin
      if (rdEn) begin
        if (mBusy > 0) begin
          mRd = mTog ? 8'h40 : 8'h00;
          mTog = !mTog;
        end else if (mId) begin
          mRd = (addr == 0) ? MFR : (addr == 1) ? DEV : 8'h00;
        end else begin
          mRd = mMem[addr % DEPTH];
        end
      end
      if (mBusy > 0) mBusy--;
      else if (wrEn) modelWrite();
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk("R2 model rdData", rdData, mRd);
      chk("R5 model busy", {7'd0, busy}, {7'd0, mBusy > 0});
    end
  end

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA);
    wr(17'h02AAA, 8'h55);
  endtask

  task automatic startErase();
    unlock();
    wr(17'h05555, 8'h80);
    unlock();
    wr(17'h05555, 8'h10);
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] v, v2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    chk("R1 reset rdData", rdData, 8'h00);
    chk("R1 reset busy", {7'd0, busy}, 8'h00);

    // R5: full erase
    startErase();
    waitIdle(n);
    chk("R5 busy length", 8'(n == DEPTH), 8'h01);
    rd(17'h00000, v); chk("R5 erased low", v, 8'hFF);
    rd(17'h007FF, v); chk("R5 erased top", v, 8'hFF);

    // R7: program, then AND
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00123, 8'h5A);
    rd(17'h00123, v); chk("R7 program", v, 8'h5A);
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00123, 8'hF0);
    rd(17'h00123, v); chk("R7 and-only", v, 8'h50);

    // R2: hold without read strobe
    repeat (4) @(negedge clk);
    chk("R2 hold", rdData, 8'h50);

    // R10: aliasing
    rd(17'h00123 + 17'(DEPTH), v); chk("R10 alias", v, 8'h50);

    // R3 / R4: identification mode
    unlock(); wr(17'h05555, 8'h90);
    rd(17'h00000, v); chk("R3 maker", v, MFR);
    rd(17'h00001, v); chk("R3 device", v, DEV);
    rd(17'h00005, v); chk("R3 other", v, 8'h00);
    unlock(); wr(17'h05555, 8'hF0);
    rd(17'h00123, v); chk("R4 exit id", v, 8'h50);

    // R8: broken sequences
    unlock(); wr(17'h05554, 8'hA0); wr(17'h00123, 8'h00);
    rd(17'h00123, v); chk("R8 bad cmd addr", v, 8'h50);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h11); wr(17'h05555, 8'h90);
    rd(17'h00000, v); chk("R8 bad key", v, 8'hFF);
    unlock(); wr(17'h05555, 8'h80); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h20);
    chk("R8 bad confirm busy", {7'd0, busy}, 8'h00);
    rd(17'h00123, v); chk("R8 bad confirm data", v, 8'h50);

    // R9: upper address bits ignored in matching
    wr(17'h15555, 8'hAA); wr(17'h1AAAA, 8'h55); wr(17'h15555, 8'hA0);
    wr(17'h00200, 8'h0F);
    rd(17'h00200, v); chk("R9 high unlock", v, 8'h0F);

    // R6: status reads and ignored writes during erase
    startErase();
    rd(17'h00123, v); rd(17'h00123, v2);
    chk("R6 status first", v, 8'h00);
    chk("R6 status second", v2, 8'h40);
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00300, 8'h00);
    waitIdle(n);
    rd(17'h00300, v); chk("R6 write ignored", v, 8'hFF);
    rd(17'h00123, v); chk("R5 re-erase", v, 8'hFF);

    finishRun();
  end

endmodule